// File: doc/BRIEF.md
# Configuration-Space Watchdog Countdown

This block is a watchdog timer that sits in a byte-wide configuration register space. Software arms it by writing a nonzero value to an 8-bit countdown register, keeps it alive by writing that register again, and stops it by writing zero. Reading the same register returns the time still left. A seconds tick from outside drives the countdown. A control bit switches the unit to minutes, in which case an internal prescaler divides the tick by a parameter that defaults to 60.

When the count steps from 1 to 0, the active-low timeout output goes low and a sticky status bit is set. The count then stays at zero until software writes the countdown register again. If enabled, a low pulse of a fixed number of clock cycles is also sent toward a keyboard-reset line. Keyboard and mouse activity inputs can reload the last armed value. Keyboard activity can instead stop the timer when the stop mode is selected. The register addresses come from one of two maps, chosen by a parameter.

Top module: `cfg_watchdog`

## Requirements
- R1: After reset the count, control and status registers all read 0, `tmo_n` is 1 and `kbrst_n` is 1.
- R2: A write to the count register (0xF6 in the default map, 0xF4 in the alternate map) loads the written value. A read of that register returns the current count. A rewrite is a keepalive that reloads the count, and it takes priority over a tick in the same cycle.
- R3: With control bit 3 clear, each `sec_tick` cycle lowers a nonzero count by one.
- R4: When the count goes from 1 to 0 on a tick, `tmo_n` goes low on that same clock edge and status bit 4 is set. `tmo_n` stays low until the count register is written again.
- R5: Writing 0 to the count register disarms the timer. While disarmed, ticks leave the count at 0 and `tmo_n` does not fall.
- R6: With control bit 1 (at 0xF5, or 0xF3 in the alternate map) set at expiry, `kbrst_n` is low for exactly PULSE_CYC clock cycles starting at the expiry edge. With that bit clear, `kbrst_n` stays high.
- R7: Status register 0xF7: a write with bit 4 clear clears the sticky timeout bit, and a write can never set that bit. Bits 7 and 6 are read/write. All other bits read 0.
- R8: With control bit 3 set, the count drops by one only on every MIN_DIV-th `sec_tick`. The prescaler restarts whenever the count register is written.
- R9: While armed, a `kbd_act` pulse with status bit 6 set, or a `mouse_act` pulse with status bit 7 set, reloads the count with the last nonzero value written. An activity pulse whose enable bit is clear has no effect.
- R10: While the count is 0, activity pulses have no effect on the count.
- R11: With control bit 2 set, a `kbd_act` pulse while armed sets the count to 0 without expiry: `tmo_n` stays high and status bit 4 stays clear. This stop takes priority over a keyboard reload.
- R12: Writes to addresses outside the selected map change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| sec_tick | input | 1 | One-cycle pulse per second of the time base |
| kbd_act | input | 1 | One-cycle keyboard activity pulse |
| mouse_act | input | 1 | One-cycle mouse activity pulse |
| tmo_n | output | 1 | Active-low timeout indication |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
The bench targets the 1-to-0 step. A design that decrements one tick early or late would show its timeout on the wrong tick, and one that wraps to 255 would restart the countdown instead of holding at zero. It measures the reset pulse cycle by cycle, which catches an off-by-one pulse counter. It also counts 59 and then 60 ticks in minute mode, which exposes a prescaler that divides by the wrong amount or that a kick does not restart. Activity pulses are sent while disarmed and with their enables clear, so that a reload that ignores those conditions would bring back a nonzero count. A stop-versus-reload case and random kick/tick traffic against a bench model complete the set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CNT,
        SEL_CTL,
        SEL_STS
    } reg_sel_e;

    typedef struct packed {
        logic [3:0] spare_hi;
        logic       minute;
        logic       kbd_stop;
        logic       pulse_en;
        logic       spare_lo;
    } ctl_t;

    typedef struct packed {
        logic       mouse_rld;
        logic       kbd_rld;
        logic       rsv5;
        logic       expired;
        logic [3:0] rsv_lo;
    } sts_t;

    function automatic byte_t cnt_addr(input bit alt);
        return alt ? 8'hF4 : 8'hF6;
    endfunction

    function automatic byte_t ctl_addr(input bit alt);
        return alt ? 8'hF3 : 8'hF5;
    endfunction

    function automatic byte_t sts_addr(input bit alt);
        return alt ? 8'hF7 : 8'hF7;
    endfunction

    function automatic reg_sel_e decode(input byte_t a, input bit alt);
        if (a == cnt_addr(alt))      return SEL_CNT;
        else if (a == ctl_addr(alt)) return SEL_CTL;
        else if (a == sts_addr(alt)) return SEL_STS;
        else                         return SEL_NONE;
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int MIN_DIV = 60,
    localparam int PW = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          minute,
    input  logic          sec_tick,
    output logic          unit_tick,
    output logic [PW-1:0] presc
);

    localparam logic [PW-1:0] LAST = PW'(MIN_DIV - 1);

    always_ff @(posedge clk) begin
        if (rst || restart || !minute) begin
            presc <= '0;
        end else if (sec_tick) begin
            presc <= (presc == LAST) ? '0 : presc + 1'b1;
        end
    end

    always_comb begin
        if (minute) unit_tick = sec_tick && (presc == LAST);
        else        unit_tick = sec_tick;
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  byte_t load_val,
    input  logic  stop,
    input  logic  reload,
    input  logic  unit_tick,
    output byte_t cnt,
    output logic  armed,
    output logic  expire
);

    byte_t rld_val;

    assign armed  = (cnt != '0);
    assign expire = armed && (cnt == byte_t'(1)) && unit_tick && !load && !stop && !reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            rld_val <= '0;
        end else if (load) begin
            cnt <= load_val;
            if (load_val != '0) rld_val <= load_val;
        end else if (armed) begin
            if (stop)           cnt <= '0;
            else if (reload)    cnt <= rld_val;
            else if (unit_tick) cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int PULSE_CYC = 4,
    localparam int CW = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse_n
);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)              remain <= '0;
        else if (fire)        remain <= CW'(PULSE_CYC);
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign pulse_n = (remain == '0);

endmodule

// File: rtl/cfg_watchdog.sv
module cfg_watchdog
    import wdog_pkg::*;
#(
    parameter bit ALT_MAP   = 1'b0,
    parameter int PULSE_CYC = 4,
    parameter int MIN_DIV   = 60,
    localparam int PW = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       sec_tick,
    input  logic       kbd_act,
    input  logic       mouse_act,
    output logic       tmo_n,
    output logic       kbrst_n
);

    reg_sel_e      sel;
    ctl_t          ctl;
    sts_t          sts;
    byte_t         cnt;
    logic          armed;
    logic          expire;
    logic          expired_q;
    logic          unit_tick;
    logic [PW-1:0] presc;
    logic          cnt_wr;
    logic          kb_stop;
    logic          act_reload;

    assign sel        = decode(addr, ALT_MAP);
    assign cnt_wr     = wr_en && (sel == SEL_CNT);
    assign kb_stop    = kbd_act && ctl.kbd_stop;
    assign act_reload = (kbd_act && sts.kbd_rld) || (mouse_act && sts.mouse_rld);

    wdog_prescale #(.MIN_DIV(MIN_DIV)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .restart   (cnt_wr),
        .minute    (ctl.minute),
        .sec_tick  (sec_tick),
        .unit_tick (unit_tick),
        .presc     (presc)
    );

    wdog_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (cnt_wr),
        .load_val  (wr_data),
        .stop      (kb_stop),
        .reload    (act_reload),
        .unit_tick (unit_tick),
        .cnt       (cnt),
        .armed     (armed),
        .expire    (expire)
    );

    wdog_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .fire    (expire && ctl.pulse_en),
        .pulse_n (kbrst_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            sts       <= '0;
            expired_q <= 1'b0;
        end else begin
            if (wr_en && sel == SEL_CTL) ctl <= ctl_t'(wr_data);
            if (wr_en && sel == SEL_STS) begin
                sts.mouse_rld <= wr_data[7];
                sts.kbd_rld   <= wr_data[6];
                if (!wr_data[4]) sts.expired <= 1'b0;
            end
            if (expire) sts.expired <= 1'b1;
            if (expire)      expired_q <= 1'b1;
            else if (cnt_wr) expired_q <= 1'b0;
        end
    end

    assign tmo_n = !expired_q;

    always_comb begin
        unique case (sel)
            SEL_CNT: rd_data = cnt;
            SEL_CTL: rd_data = ctl;
            SEL_STS: rd_data = {sts.mouse_rld, sts.kbd_rld, 1'b0, sts.expired, 4'b0000};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cfg_watchdog_chk.sv
module cfg_watchdog_chk #(
    parameter bit ALT_MAP = 1'b0,
    parameter int MIN_DIV = 60,
    localparam int PW = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [7:0]    addr,
    input logic [7:0]    wr_data,
    input logic          kbd_act,
    input logic          mouse_act,
    input logic [7:0]    cnt,
    input logic          unit_tick,
    input logic [PW-1:0] presc,
    input logic          tmo_n,
    input logic          kbrst_n,
    input logic          sts_exp
);

    logic [7:0] ca;
    logic       cwr;
    assign ca  = ALT_MAP ? 8'hF4 : 8'hF6;
    assign cwr = wr_en && (addr == ca);

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        cwr |=> (cnt == $past(wr_data))); // R2

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
        (cnt == 8'd0 && !cwr) |=> (cnt == 8'd0)); // R10

    AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (cnt == 8'd1 && unit_tick && !cwr && !kbd_act && !mouse_act) |=> (!tmo_n && sts_exp)); // R4

    AST_STATUS_WITH_TMO: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_exp) |-> !tmo_n); // R4

    AST_PULSE_AT_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        $fell(kbrst_n) |-> !tmo_n); // R6

    AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (rst)
        presc < PW'(MIN_DIV)); // R8

endmodule

bind cfg_watchdog cfg_watchdog_chk #(.ALT_MAP(ALT_MAP), .MIN_DIV(MIN_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .kbd_act   (kbd_act),
    .mouse_act (mouse_act),
    .cnt       (cnt),
    .unit_tick (unit_tick),
    .presc     (presc),
    .tmo_n     (tmo_n),
    .kbrst_n   (kbrst_n),
    .sts_exp   (sts.expired)
);

// File: tb/cfg_watchdog_bench.sv
module cfg_watchdog_bench;

    localparam int PULSE = 4;
    localparam int DIV   = 60;
    localparam logic [7:0] A_CNT = 8'hF6;
    localparam logic [7:0] A_CTL = 8'hF5;
    localparam logic [7:0] A_STS = 8'hF7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sec_tick = 1'b0;
    logic       kbd_act = 1'b0;
    logic       mouse_act = 1'b0;
    logic       tmo_n;
    logic       kbrst_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cfg_watchdog #(.ALT_MAP(1'b0), .PULSE_CYC(PULSE), .MIN_DIV(DIV)) u_cfg_watchdog (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .sec_tick  (sec_tick),
        .kbd_act   (kbd_act),
        .mouse_act (mouse_act),
        .tmo_n     (tmo_n),
        .kbrst_n   (kbrst_n)
    );

    function automatic logic [7:0] model_step(input logic [7:0] c, input bit w,
                                              input logic [7:0] d, input bit t);
        if (w)               return d;
        else if (t && c != 0) return c - 8'd1;
        else                  return c;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1; cyc(); sec_tick = 1'b0; cyc();
        end
    endtask

    task automatic kbd();
        kbd_act = 1'b1; cyc(); kbd_act = 1'b0;
    endtask

    task automatic mouse();
        mouse_act = 1'b1; cyc(); mouse_act = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] expc;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1 reset state
        rd(A_CNT, v); check("R1 cnt", v, 8'h00);
        rd(A_CTL, v); check("R1 ctl", v, 8'h00);
        rd(A_STS, v); check("R1 sts", v, 8'h00);
        check("R1 tmo_n", {7'd0, tmo_n}, 8'd1);
        check("R1 kbrst_n", {7'd0, kbrst_n}, 8'd1);

        // R2 load and readback, R3 seconds countdown
        wr(A_CNT, 8'd5); rd(A_CNT, v); check("R2 load", v, 8'd5);
        ticks(2); rd(A_CNT, v); check("R3 two ticks", v, 8'd3);
        wr(A_CNT, 8'd5); rd(A_CNT, v); check("R2 keepalive", v, 8'd5);

        // R2 write beats tick in same cycle
        addr = A_CNT; wr_data = 8'd9; wr_en = 1'b1; sec_tick = 1'b1; cyc();
        wr_en = 1'b0; sec_tick = 1'b0;
        rd(A_CNT, v); check("R2 write over tick", v, 8'd9);

        // R4 expiry
        ticks(8); rd(A_CNT, v); check("R4 at one", v, 8'd1);
        check("R4 tmo_n before", {7'd0, tmo_n}, 8'd1);
        sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
        check("R4 tmo_n low", {7'd0, tmo_n}, 8'd0);
        check("R6 no pulse when disabled", {7'd0, kbrst_n}, 8'd1);
        rd(A_STS, v); check("R4 status set", v, 8'h10);
        ticks(3); rd(A_CNT, v); check("R4 holds at zero", v, 8'd0);
        check("R4 tmo_n stays low", {7'd0, tmo_n}, 8'd0);

        // R7 status clear; cannot be set by write
        wr(A_STS, 8'h10); rd(A_STS, v); check("R7 write 1 keeps", v, 8'h10);
        wr(A_STS, 8'h2F); rd(A_STS, v); check("R7 clear and reserved", v, 8'h00);
        check("R4 tmo_n until rewrite", {7'd0, tmo_n}, 8'd0);
        wr(A_CNT, 8'd3); check("R4 tmo_n released", {7'd0, tmo_n}, 8'd1);

        // R5 disarm
        wr(A_CNT, 8'd0); ticks(4); rd(A_CNT, v); check("R5 disarmed", v, 8'd0);
        check("R5 no timeout", {7'd0, tmo_n}, 8'd1);

        // R6 reset pulse width
        wr(A_CTL, 8'h02); rd(A_CTL, v); check("R6 ctl readback", v, 8'h02);
        wr(A_CNT, 8'd1);
        sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
        for (int i = 0; i < PULSE; i++) begin
            check("R6 pulse low", {7'd0, kbrst_n}, 8'd0);
            cyc();
        end
        check("R6 pulse ends", {7'd0, kbrst_n}, 8'd1);

        // R8 minute mode
        wr(A_CTL, 8'h08); wr(A_CNT, 8'd2);
        ticks(DIV - 1); rd(A_CNT, v); check("R8 59 ticks", v, 8'd2);
        ticks(1); rd(A_CNT, v); check("R8 60 ticks", v, 8'd1);
        ticks(30); wr(A_CNT, 8'd2); ticks(DIV - 1); rd(A_CNT, v);
        check("R8 kick restarts prescaler", v, 8'd2);
        wr(A_CTL, 8'h00);

        // R9 activity reload
        wr(A_STS, 8'h40); wr(A_CNT, 8'd10); ticks(3);
        rd(A_CNT, v); check("R9 before", v, 8'd7);
        kbd(); rd(A_CNT, v); check("R9 kbd reload", v, 8'd10);
        ticks(2); mouse(); rd(A_CNT, v); check("R9 mouse disabled", v, 8'd8);
        wr(A_STS, 8'h80); mouse(); rd(A_CNT, v); check("R9 mouse reload", v, 8'd10);
        ticks(1); kbd(); rd(A_CNT, v); check("R9 kbd disabled", v, 8'd9);

        // R10 disarmed activity
        wr(A_STS, 8'hC0); wr(A_CNT, 8'd0);
        kbd(); mouse(); rd(A_CNT, v); check("R10 no reload", v, 8'd0);

        // R11 keyboard stop wins over reload
        wr(A_CTL, 8'h04); wr(A_CNT, 8'd6); kbd();
        rd(A_CNT, v); check("R11 stopped", v, 8'd0);
        check("R11 no timeout", {7'd0, tmo_n}, 8'd1);
        rd(A_STS, v); check("R11 status clear", v, 8'hC0);
        wr(A_CTL, 8'h00); wr(A_STS, 8'h00);

        // R12 unmapped addresses
        wr(A_CNT, 8'd4); wr(8'hF4, 8'd9); wr(8'h30, 8'hFF);
        rd(A_CNT, v); check("R12 count untouched", v, 8'd4);
        rd(8'hF4, v); check("R12 read unmapped", v, 8'h00);
        rd(A_CTL, v); check("R12 ctl untouched", v, 8'h00);

        // R3 R2 random traffic against model
        expc = 8'd4;
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            bit w;
            bit t;
            logic [7:0] d;
            w = ($urandom % 8) == 0;
            t = ($urandom % 2) == 0;
            d = 8'($urandom % 12);
            addr = A_CNT; wr_data = d; wr_en = w; sec_tick = t;
            cyc();
            wr_en = 1'b0; sec_tick = 1'b0;
            expc = model_step(expc, w, d, t);
            rd(A_CNT, v); check("R3 random count", v, expc);
        end

        done = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 100000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule